// File: doc/BRIEF.md
# BCD Calendar Clock with Freezable Host View

This block keeps time of day and the calendar in packed BCD: hundredths of a second, seconds, minutes, hours, day of the week, date, month and a two-digit year. It holds two copies of every field. The internal copy advances on each pulse of a 100 Hz tick input. The host-visible copy is what the register port returns. While the copy is live, it is reloaded from the internal counters on every tick.

A host accesses the block through a synchronous register port: a 6-bit address, a write strobe, a write byte and a combinational read byte. The command register holds a transfer-enable bit. Clearing that bit freezes the host view so that a multi-byte read or write sees a consistent snapshot, and the internal counters keep running meanwhile. Time or date fields written during the freeze are pushed into the internal counters when transfer-enable is set again. The month register also holds an active-low oscillator enable, which halts all counting. The block drives a one-cycle strobe when the seconds roll over, for use by alarm logic placed next to it.

Top module: `bcd_calclock`

## Requirements
- R1: After reset the host view reads hundredths 00, seconds 00, minutes 00, hours 00 (24-hour), day 1, date 01, month 81h (oscillator stopped, month 01), year 00 and command 80h (transfer enabled). The address map is: 0 hundredths, 1 seconds, 2 minutes, 4 hours, 6 day, 8 date, 9 month, 0Ah year, 0Bh command. Any other address reads 00h.
- R2: Each tick with the oscillator running advances the hundredths in BCD. A step from 99 to 00 carries into the seconds, 59 to 00 in the seconds carries into the minutes, and 59 to 00 in the minutes carries into the hours.
- R3: In 24-hour mode (hour bit 6 = 0, bits 5:0 BCD 00–23) the hour wraps from 23 to 00. This wrap advances the day of the week and the date.
- R4: In 12-hour mode (hour bit 6 = 1, bit 5 = PM, bits 4:0 BCD 01–12) the sequence is 11 AM → 12 PM → 01 PM and 11 PM → 12 AM. Only the step from 11 PM to 12 AM advances the day and the date.
- R5: The day of the week counts 1 to 7 and wraps from 7 back to 1 at midnight.
- R6: The date wraps to 01 after 30 in April, June, September and November, and after 31 in the other long months, and then the month advances. The month wraps from 12 to 01 and advances the year, and the year wraps from 99 to 00.
- R7: February ends at 29 when the two-digit year is divisible by 4, including 00, and at 28 otherwise.
- R8: Month register bit 7 set to 1 stops all counting and all host-view refreshes. The bit reads back as written.
- R9: With command bit 7 at 0 the host view stays unchanged apart from host writes, while the internal counters keep running. With the bit at 1, every advancing tick copies the whole internal set into the host view.
- R10: A write with transfer-enable at 1 updates both copies in the same cycle. A write while frozen updates only the host view, and that field is loaded into the internal counter on the write that sets transfer-enable back to 1.
- R11: Unused bits read 0 whatever was written: bit 7 of seconds, minutes and hours, bits 7:3 of day, bits 7:6 of date, bits 6:5 of month, and bits 6:0 of the command register.
- R12: `sec_roll` is high for exactly one cycle, the cycle after the tick that takes the internal seconds from 59 to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_100hz | input | 1 | One-cycle pulse every hundredth of a second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register address for read and write |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for `addr`, from the host view |
| sec_roll | output | 1 | One-cycle strobe on seconds 59→00 |

## Verification
The bench drives time to the last hundredth of a day and checks the full carry into the calendar. It does this for a non-leap February, leap Februaries (including year 00), a 30-day month and New Year of year 99. A broken carry chain or month-length table would show a date such as 29 or 32 where 01 belongs. The three 12-hour boundaries are checked one by one, because a design that toggles PM on the wrong step, or advances the date at noon, reads back the wrong hour byte or the wrong date. A long freeze, with writes made during it, checks that the host view stays still while the internal time moves on, and that the frozen writes reach the internal counters at re-enable. A design that froze the internal counters too, or dropped the pending write, would show the wrong time after the next tick. Random mixes of ticks, field writes, freezes and oscillator stops are compared against a model of the calendar kept in plain binary.

// File: rtl/bcdclk_pkg.sv
package bcdclk_pkg;

    localparam int NUM_FIELDS = 8;
    localparam int FIELD_IDX_W = $clog2(NUM_FIELDS);

    // field indices, in carry order
    localparam logic [FIELD_IDX_W-1:0] FLD_HUND  = 3'd0;
    localparam logic [FIELD_IDX_W-1:0] FLD_SEC   = 3'd1;
    localparam logic [FIELD_IDX_W-1:0] FLD_MIN   = 3'd2;
    localparam logic [FIELD_IDX_W-1:0] FLD_HOUR  = 3'd3;
    localparam logic [FIELD_IDX_W-1:0] FLD_DAY   = 3'd4;
    localparam logic [FIELD_IDX_W-1:0] FLD_DATE  = 3'd5;
    localparam logic [FIELD_IDX_W-1:0] FLD_MONTH = 3'd6;
    localparam logic [FIELD_IDX_W-1:0] FLD_YEAR  = 3'd7;

    // one full set of calendar fields, only the implemented bits
    typedef struct packed {
        logic [7:0] hund;
        logic [6:0] sec;
        logic [6:0] min;
        logic [6:0] hour;   // [6] 12h mode, [5] PM or tens bit, [4:0] BCD
        logic [2:0] day;
        logic [5:0] date;
        logic [4:0] month;
        logic [7:0] year;
    } cal_t;

    localparam cal_t CAL_RESET = '{hund: 8'h00, sec: 7'h00, min: 7'h00,
                                   hour: 7'h00, day: 3'd1, date: 6'h01,
                                   month: 5'h01, year: 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // last BCD date of a month, leap when the year is divisible by 4
    function automatic logic [5:0] month_last(input logic [4:0] m, input logic [7:0] y);
        logic [6:0] ybin;
        ybin = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
        case (m)
            5'h02:                      return (ybin[1:0] == 2'b00) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

    function automatic logic [7:0] get_field(input cal_t c, input logic [FIELD_IDX_W-1:0] f);
        case (f)
            FLD_HUND:  return c.hund;
            FLD_SEC:   return {1'b0, c.sec};
            FLD_MIN:   return {1'b0, c.min};
            FLD_HOUR:  return {1'b0, c.hour};
            FLD_DAY:   return {5'b0, c.day};
            FLD_DATE:  return {2'b0, c.date};
            FLD_MONTH: return {3'b0, c.month};
            default:   return c.year;
        endcase
    endfunction

    function automatic cal_t set_field(input cal_t c, input logic [FIELD_IDX_W-1:0] f,
                                       input logic [7:0] v);
        cal_t r;
        r = c;
        case (f)
            FLD_HUND:  r.hund  = v;
            FLD_SEC:   r.sec   = v[6:0];
            FLD_MIN:   r.min   = v[6:0];
            FLD_HOUR:  r.hour  = v[6:0];
            FLD_DAY:   r.day   = v[2:0];
            FLD_DATE:  r.date  = v[5:0];
            FLD_MONTH: r.month = v[4:0];
            default:   r.year  = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bcdclk_tod_step.sv
module bcdclk_tod_step
    import bcdclk_pkg::*;
(
    input  logic       step_i,
    input  cal_t       cur_i,
    output logic [7:0] hund_o,
    output logic [6:0] sec_o,
    output logic [6:0] min_o,
    output logic [6:0] hour_o,
    output logic       sec_wrap_o,
    output logic       day_carry_o
);

    logic [7:0] hund_inc, sec_inc, min_inc, h12_inc, h24_inc;
    logic       hund_last, sec_last, min_last, hour_last;
    logic       c_sec, c_min, c_hour;
    logic [6:0] hour_nxt;
    logic       pm;

    always_comb begin
        hund_inc = bcd_inc(cur_i.hund);
        sec_inc  = bcd_inc({1'b0, cur_i.sec});
        min_inc  = bcd_inc({1'b0, cur_i.min});
        h12_inc  = bcd_inc({3'b0, cur_i.hour[4:0]});
        h24_inc  = bcd_inc({2'b0, cur_i.hour[5:0]});
        pm       = cur_i.hour[5];

        hund_last = (cur_i.hund == 8'h99);
        sec_last  = (cur_i.sec == 7'h59);
        min_last  = (cur_i.min == 7'h59);

        if (cur_i.hour[6]) begin
            hour_last = (cur_i.hour[4:0] == 5'h11) && pm;
            if (cur_i.hour[4:0] == 5'h12)      hour_nxt = {1'b1, pm, 5'h01};
            else if (cur_i.hour[4:0] == 5'h11) hour_nxt = {1'b1, ~pm, 5'h12};
            else                               hour_nxt = {1'b1, pm, h12_inc[4:0]};
        end else begin
            hour_last = (cur_i.hour[5:0] == 6'h23);
            hour_nxt  = hour_last ? 7'h00 : {1'b0, h24_inc[5:0]};
        end

        c_sec  = step_i && hund_last;
        c_min  = c_sec && sec_last;
        c_hour = c_min && min_last;

        hund_o      = step_i ? (hund_last ? 8'h00 : hund_inc) : cur_i.hund;
        sec_o       = c_sec  ? (sec_last ? 7'h00 : sec_inc[6:0]) : cur_i.sec;
        min_o       = c_min  ? (min_last ? 7'h00 : min_inc[6:0]) : cur_i.min;
        hour_o      = c_hour ? hour_nxt : cur_i.hour;
        sec_wrap_o  = c_min;
        day_carry_o = c_hour && hour_last;
    end

endmodule

// File: rtl/bcdclk_date_step.sv
module bcdclk_date_step
    import bcdclk_pkg::*;
(
    input  logic       step_i,
    input  cal_t       cur_i,
    output logic [2:0] day_o,
    output logic [5:0] date_o,
    output logic [4:0] month_o,
    output logic [7:0] year_o
);

    logic [7:0] date_inc, month_inc, year_inc;
    logic       date_last, month_last_q, year_last;
    logic       c_month, c_year;

    always_comb begin
        date_inc  = bcd_inc({2'b0, cur_i.date});
        month_inc = bcd_inc({3'b0, cur_i.month});
        year_inc  = bcd_inc(cur_i.year);

        date_last    = (cur_i.date == month_last(cur_i.month, cur_i.year));
        month_last_q = (cur_i.month == 5'h12);
        year_last    = (cur_i.year == 8'h99);

        c_month = step_i && date_last;
        c_year  = c_month && month_last_q;

        if (step_i) day_o = (cur_i.day == 3'd7) ? 3'd1 : cur_i.day + 3'd1;
        else        day_o = cur_i.day;

        date_o  = step_i  ? (date_last ? 6'h01 : date_inc[5:0]) : cur_i.date;
        month_o = c_month ? (month_last_q ? 5'h01 : month_inc[4:0]) : cur_i.month;
        year_o  = c_year  ? (year_last ? 8'h00 : year_inc) : cur_i.year;
    end

endmodule

// File: rtl/bcd_calclock.sv
module bcd_calclock
    import bcdclk_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_100hz,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              sec_roll
);

    localparam logic [ADDR_W-1:0] AD_HUND  = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] AD_SEC   = ADDR_W'(8'h01);
    localparam logic [ADDR_W-1:0] AD_MIN   = ADDR_W'(8'h02);
    localparam logic [ADDR_W-1:0] AD_HOUR  = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] AD_DAY   = ADDR_W'(8'h06);
    localparam logic [ADDR_W-1:0] AD_DATE  = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] AD_MONTH = ADDR_W'(8'h09);
    localparam logic [ADDR_W-1:0] AD_YEAR  = ADDR_W'(8'h0A);
    localparam logic [ADDR_W-1:0] AD_CMD   = ADDR_W'(8'h0B);

    typedef struct packed {
        cal_t                  int_cal;   // running counters
        cal_t                  vis_cal;   // host view
        logic [NUM_FIELDS-1:0] pend;      // written while frozen
        logic                  te;
        logic                  osc_off;
        logic                  sec_roll;
    } state_t;

    localparam state_t ST_RESET = '{int_cal: CAL_RESET, vis_cal: CAL_RESET,
                                    pend: '0, te: 1'b1, osc_off: 1'b1,
                                    sec_roll: 1'b0};

    state_t st_q, st_d;

    logic                   step;
    logic                   fld_hit;
    logic [FIELD_IDX_W-1:0] fld_idx;
    logic [7:0]             hund_n;
    logic [6:0]             sec_n, min_n, hour_n;
    logic                   sec_wrap, day_carry;
    logic [2:0]             day_n;
    logic [5:0]             date_n;
    logic [4:0]             month_n;
    logic [7:0]             year_n;

    assign step = tick_100hz && !st_q.osc_off;

    bcdclk_tod_step u_tod (
        .step_i      (step),
        .cur_i       (st_q.int_cal),
        .hund_o      (hund_n),
        .sec_o       (sec_n),
        .min_o       (min_n),
        .hour_o      (hour_n),
        .sec_wrap_o  (sec_wrap),
        .day_carry_o (day_carry)
    );

    bcdclk_date_step u_date (
        .step_i  (day_carry),
        .cur_i   (st_q.int_cal),
        .day_o   (day_n),
        .date_o  (date_n),
        .month_o (month_n),
        .year_o  (year_n)
    );

    // address to field index
    always_comb begin
        fld_hit = 1'b1;
        fld_idx = FLD_HUND;
        case (addr)
            AD_HUND:  fld_idx = FLD_HUND;
            AD_SEC:   fld_idx = FLD_SEC;
            AD_MIN:   fld_idx = FLD_MIN;
            AD_HOUR:  fld_idx = FLD_HOUR;
            AD_DAY:   fld_idx = FLD_DAY;
            AD_DATE:  fld_idx = FLD_DATE;
            AD_MONTH: fld_idx = FLD_MONTH;
            AD_YEAR:  fld_idx = FLD_YEAR;
            default:  fld_hit = 1'b0;
        endcase
    end

    // next state
    always_comb begin
        st_d = st_q;

        st_d.int_cal.hund  = hund_n;
        st_d.int_cal.sec   = sec_n;
        st_d.int_cal.min   = min_n;
        st_d.int_cal.hour  = hour_n;
        st_d.int_cal.day   = day_n;
        st_d.int_cal.date  = date_n;
        st_d.int_cal.month = month_n;
        st_d.int_cal.year  = year_n;
        st_d.sec_roll      = sec_wrap;

        if (wr_en && fld_hit) begin
            st_d.vis_cal = set_field(st_d.vis_cal, fld_idx, wr_data);
            if (st_q.te) st_d.int_cal = set_field(st_d.int_cal, fld_idx, wr_data);
            else         st_d.pend[fld_idx] = 1'b1;
            if (fld_idx == FLD_MONTH) st_d.osc_off = wr_data[7];
        end else if (wr_en && addr == AD_CMD) begin
            st_d.te = wr_data[7];
            if (wr_data[7] && !st_q.te) begin
                for (int f = 0; f < NUM_FIELDS; f++) begin
                    if (st_q.pend[f])
                        st_d.int_cal = set_field(st_d.int_cal, FIELD_IDX_W'(f),
                                                 get_field(st_q.vis_cal, FIELD_IDX_W'(f)));
                end
                st_d.pend = '0;
            end
        end

        if (step && st_q.te) st_d.vis_cal = st_d.int_cal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    // host read path
    always_comb begin
        rd_data = 8'h00;
        if (fld_hit) rd_data = get_field(st_q.vis_cal, fld_idx);
        if (fld_hit && fld_idx == FLD_MONTH) rd_data[7] = st_q.osc_off;
        if (addr == AD_CMD) rd_data = {st_q.te, 7'b0};
    end

    assign sec_roll = st_q.sec_roll;

endmodule

// File: rtl/bcd_calclock_chk.sv
module bcd_calclock_chk
    import bcdclk_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_100hz,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rd_data,
    input logic              sec_roll,
    input logic              te_q,
    input logic              osc_q,
    input cal_t              vis_q,
    input cal_t              int_q
);

    // R12: strobe only follows a tick
    assert_roll_after_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sec_roll |-> $past(tick_100hz));

    // R12: strobe lasts one cycle
    assert_roll_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sec_roll |=> !sec_roll);

    // R9: frozen view holds without host writes
    assert_view_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!te_q && !wr_en) |=> $stable(vis_q));

    // R8: stopped oscillator holds the internal counters
    assert_osc_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_q && !wr_en) |=> $stable(int_q));

    // R11: unused bits of the month and day registers read zero
    assert_month_unused_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(8'h09)) |-> (rd_data[6:5] == 2'b00));

    assert_day_unused_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(8'h06)) |-> (rd_data[7:3] == 5'b0));

endmodule

bind bcd_calclock bcd_calclock_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_100hz (tick_100hz),
    .wr_en      (wr_en),
    .addr       (addr),
    .rd_data    (rd_data),
    .sec_roll   (sec_roll),
    .te_q       (st_q.te),
    .osc_q      (st_q.osc_off),
    .vis_q      (st_q.vis_cal),
    .int_q      (st_q.int_cal)
);

// File: tb/bcd_calclock_tb_top.sv
module bcd_calclock_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] addr = 6'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sec_roll;

    always #5 clk = ~clk;

    bcd_calclock dut_i (
        .clk(clk), .rst_n(rst_n), .tick_100hz(tick), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .sec_roll(sec_roll)
    );

    int n_chk = 0;
    int n_bad = 0;

    // binary model: index 0 hund,1 sec,2 min,3 hour(0-23),4 day,5 date,6 month,7 year
    int mi[8];
    int mv[8];
    bit mi_12, mv_12;
    bit pend[8];
    bit m_te, m_osc;

    function automatic int fidx(input logic [5:0] a);
        case (a)
            6'h00: return 0; 6'h01: return 1; 6'h02: return 2; 6'h04: return 3;
            6'h06: return 4; 6'h08: return 5; 6'h09: return 6; 6'h0A: return 7;
            default: return -1;
        endcase
    endfunction

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int dim(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] enc(input logic [5:0] a);
        int f;
        int h;
        f = fidx(a);
        if (a == 6'h0B) return {m_te, 7'b0};
        if (f < 0) return 8'h00;
        if (f == 3) begin
            if (!mv_12) return to_bcd(mv[3]);
            h = (mv[3] % 12 == 0) ? 12 : mv[3] % 12;
            return 8'h40 | ((mv[3] >= 12) ? 8'h20 : 8'h00) | to_bcd(h);
        end
        if (f == 6) return {m_osc, 7'b0} | to_bcd(mv[6]);
        return to_bcd(mv[f]);
    endfunction

    function automatic int dec_val(input int f, input logic [7:0] d);
        int h;
        case (f)
            1, 2: return from_bcd({1'b0, d[6:0]});
            3: begin
                if (d[6]) begin
                    h = from_bcd({3'b0, d[4:0]});
                    return (h % 12) + (d[5] ? 12 : 0);
                end
                return from_bcd({2'b0, d[5:0]});
            end
            4: return int'(d[2:0]);
            5: return from_bcd({2'b0, d[5:0]});
            6: return from_bcd({3'b0, d[4:0]});
            default: return from_bcd(d);
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // one clock: drive, update the model, check the strobe
    task automatic step(input bit tk, input bit we, input logic [5:0] a,
                        input logic [7:0] d, input bit raw);
        bit exp_roll;
        bit te_old, osc_old;
        int f;
        exp_roll = 1'b0;
        te_old = m_te;
        osc_old = m_osc;
        @(negedge clk);
        tick = tk; wr_en = we; addr = a; wr_data = d;
        if (tk && !osc_old) begin
            mi[0]++;
            if (mi[0] == 100) begin
                mi[0] = 0; mi[1]++;
                if (mi[1] == 60) begin
                    mi[1] = 0; exp_roll = 1'b1; mi[2]++;
                    if (mi[2] == 60) begin
                        mi[2] = 0; mi[3]++;
                        if (mi[3] == 24) begin
                            mi[3] = 0;
                            mi[4] = mi[4] % 7 + 1;
                            mi[5]++;
                            if (mi[5] > dim(mi[6], mi[7])) begin
                                mi[5] = 1; mi[6]++;
                                if (mi[6] > 12) begin
                                    mi[6] = 1; mi[7] = (mi[7] + 1) % 100;
                                end
                            end
                        end
                    end
                end
            end
        end
        if (we && !raw) begin
            f = fidx(a);
            if (f >= 0) begin
                mv[f] = dec_val(f, d);
                if (f == 3) mv_12 = d[6];
                if (te_old) begin
                    mi[f] = mv[f];
                    if (f == 3) mi_12 = d[6];
                end else pend[f] = 1'b1;
                if (f == 6) m_osc = d[7];
            end else if (a == 6'h0B) begin
                if (d[7] && !te_old) begin
                    for (int k = 0; k < 8; k++) begin
                        if (pend[k]) begin
                            mi[k] = mv[k];
                            if (k == 3) mi_12 = mv_12;
                        end
                        pend[k] = 1'b0;
                    end
                end
                m_te = d[7];
            end
        end
        if (tk && te_old && !osc_old) begin
            for (int k = 0; k < 8; k++) mv[k] = mi[k];
            mv_12 = mi_12;
        end
        @(posedge clk);
        #2;
        tick = 1'b0; wr_en = 1'b0;
        chk("R12", "sec_roll", {7'b0, sec_roll}, {7'b0, exp_roll});
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        step(1'b0, 1'b1, a, d, 1'b0);
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 6'h00, 8'h00, 1'b0);
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; wr_en = 1'b0; tick = 1'b0;
        #1;
        v = rd_data;
    endtask

    task automatic check_all(input string req);
        logic [7:0] v;
        logic [5:0] al[10] = '{6'h00, 6'h01, 6'h02, 6'h04, 6'h06, 6'h08,
                               6'h09, 6'h0A, 6'h0B, 6'h03};
        for (int i = 0; i < 10; i++) begin
            rd(al[i], v);
            chk(req, $sformatf("addr %02h", al[i]), v, enc(al[i]));
        end
    endtask

    task automatic check_one(input string req, input logic [5:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, $sformatf("addr %02h", a), v, exp);
    endtask

    task automatic set_eod(input logic [7:0] hr);
        wr(6'h00, 8'h99); wr(6'h01, 8'h59); wr(6'h02, 8'h59); wr(6'h04, hr);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int r, f;
        logic [7:0] d;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 8; k++) begin mi[k] = 0; mv[k] = 0; pend[k] = 1'b0; end
        mi[4] = 1; mi[5] = 1; mi[6] = 1;
        mv[4] = 1; mv[5] = 1; mv[6] = 1;
        mi_12 = 1'b0; mv_12 = 1'b0; m_te = 1'b1; m_osc = 1'b1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state and map, R8 stopped at reset
        check_all("R1");
        check_one("R1", 6'h09, 8'h81);
        check_one("R1", 6'h0B, 8'h80);
        tk(3);
        check_all("R8");

        // R11 unused bits, oscillator still stopped
        step(1'b0, 1'b1, 6'h01, 8'hFF, 1'b1); check_one("R11", 6'h01, 8'h7F);
        step(1'b0, 1'b1, 6'h04, 8'hFF, 1'b1); check_one("R11", 6'h04, 8'h7F);
        step(1'b0, 1'b1, 6'h06, 8'hFF, 1'b1); check_one("R11", 6'h06, 8'h07);
        step(1'b0, 1'b1, 6'h08, 8'hFF, 1'b1); check_one("R11", 6'h08, 8'h3F);
        step(1'b0, 1'b1, 6'h09, 8'hFF, 1'b1); check_one("R11", 6'h09, 8'h9F);
        step(1'b0, 1'b1, 6'h0B, 8'h80, 1'b1); check_one("R11", 6'h0B, 8'h80);
        wr(6'h01, 8'h00); wr(6'h04, 8'h00); wr(6'h06, 8'h01);
        wr(6'h08, 8'h01); wr(6'h09, 8'h81);
        check_all("R11");

        // R2 start oscillator, carry hundredths into seconds
        wr(6'h09, 8'h01);
        wr(6'h00, 8'h98);
        tk(1); check_one("R2", 6'h00, 8'h99);
        tk(1); check_one("R2", 6'h00, 8'h00); check_one("R2", 6'h01, 8'h01);

        // R3 R5 R7 midnight, day 7 -> 1, non-leap February
        wr(6'h06, 8'h07); wr(6'h08, 8'h28); wr(6'h09, 8'h02); wr(6'h0A, 8'h23);
        set_eod(8'h23);
        tk(1);
        check_one("R3", 6'h04, 8'h00);
        check_one("R5", 6'h06, 8'h01);
        check_one("R7", 6'h08, 8'h01);
        check_one("R7", 6'h09, 8'h03);
        check_all("R3");

        // R7 leap years 24 and 00
        wr(6'h0A, 8'h24); wr(6'h09, 8'h02); wr(6'h08, 8'h28);
        set_eod(8'h23); tk(1);
        check_one("R7", 6'h08, 8'h29);
        set_eod(8'h23); tk(1);
        check_one("R7", 6'h08, 8'h01); check_one("R7", 6'h09, 8'h03);
        wr(6'h0A, 8'h00); wr(6'h09, 8'h02); wr(6'h08, 8'h28);
        set_eod(8'h23); tk(1);
        check_one("R7", 6'h08, 8'h29);

        // R6 30-day month and new year from 99
        wr(6'h09, 8'h04); wr(6'h08, 8'h30);
        set_eod(8'h23); tk(1);
        check_one("R6", 6'h08, 8'h01); check_one("R6", 6'h09, 8'h05);
        wr(6'h09, 8'h12); wr(6'h08, 8'h31); wr(6'h0A, 8'h99);
        set_eod(8'h23); tk(1);
        check_one("R6", 6'h09, 8'h01); check_one("R6", 6'h0A, 8'h00);
        check_all("R6");

        // R4 12-hour boundaries
        wr(6'h08, 8'h10);
        set_eod(8'h71); tk(1);
        check_one("R4", 6'h04, 8'h52); check_one("R4", 6'h08, 8'h11);
        set_eod(8'h51); tk(1);
        check_one("R4", 6'h04, 8'h72); check_one("R4", 6'h08, 8'h11);
        set_eod(8'h72); tk(1);
        check_one("R4", 6'h04, 8'h61);
        check_all("R4");

        // R9 R10 freeze, write while frozen, re-enable
        wr(6'h0B, 8'h00);
        tk(150);
        check_all("R9");
        wr(6'h01, 8'h30);
        check_one("R10", 6'h01, 8'h30);
        tk(20);
        check_all("R9");
        wr(6'h0B, 8'h80);
        check_all("R10");
        tk(1);
        check_all("R10");
        wr(6'h02, 8'h45);
        check_one("R10", 6'h02, 8'h45);
        tk(1);
        check_all("R10");

        // R8 oscillator stop and restart
        wr(6'h09, 8'h81);
        tk(5);
        check_all("R8");
        wr(6'h09, 8'h01);
        tk(1);
        check_all("R8");

        // random mix against the model
        for (int i = 0; i < 4000; i++) begin
            r = $urandom_range(0, 99);
            if (r < 55) tk(1);
            else if (r < 85) begin
                f = m_te ? $urandom_range(0, 7) : $urandom_range(0, 5);
                if ((f == 6 || f == 7) && mi[5] > 28) f = 0;
                case (f)
                    0: wr(6'h00, to_bcd($urandom_range(0, 99)));
                    1: wr(6'h01, to_bcd($urandom_range(0, 59)));
                    2: wr(6'h02, to_bcd($urandom_range(0, 59)));
                    3: begin
                        if ($urandom_range(0, 1) == 1)
                            d = 8'h40 | ($urandom_range(0, 1) == 1 ? 8'h20 : 8'h00)
                                | to_bcd($urandom_range(1, 12));
                        else d = to_bcd($urandom_range(0, 23));
                        wr(6'h04, d);
                    end
                    4: wr(6'h06, 8'($urandom_range(1, 7)));
                    5: wr(6'h08, to_bcd($urandom_range(1, 28)));
                    6: wr(6'h09, {m_osc, 7'b0} | to_bcd($urandom_range(1, 12)));
                    default: wr(6'h0A, to_bcd($urandom_range(0, 99)));
                endcase
            end else if (r < 93) wr(6'h0B, m_te ? 8'h00 : 8'h80);
            else if (r < 95 && m_te) wr(6'h09, {~m_osc, 7'b0} | to_bcd(mi[6]));
            else step(1'b0, 1'b0, 6'h00, 8'h00, 1'b0);
            if (i % 40 == 39) check_all("R2");
        end
        check_all("R9");

        finish_run();
    end

endmodule